// File: doc/BRIEF.md
# External Data Memory Bus Sequencer

This block performs one read or one write to an external data memory over a bus whose low byte carries first the address and then the data. A user-side request starts the sequence. The block first drives the address and pulses the latch enable, so that an external latch can hold the low address byte. It then asserts the active-low read or write strobe and moves data across the shared byte. Every edge falls on a whole number of clock periods, counted from the falling edge of the latch enable.

During a read, the block releases the shared byte before the read strobe falls. It captures the byte in the last clock period in which the strobe is low. It then waits out a turnaround window, because the memory may still be driving the bus. During a write, the block puts the data on the bus ahead of the strobe and keeps it there past the rising edge of the strobe. A one-cycle done pulse marks the end of every access. Requests that arrive while an access is running are ignored.

With the default parameters, the latch enable is high for 2 cycles and the strobe falls 3 cycles after the latch enable falls. The strobe is low for 6 cycles. A read then has 2 cycles of turnaround, and a write holds its data for 1 cycle.

Top module: `xmem_seq`

## Requirements
- R1: While reset is asserted, and after it is released with no request pending, `rd_n` and `wr_n` are high, `ale` is low, `ad_oe` is low and `done` is low.
- R2: A request is accepted at a clock edge where the sequencer is idle and `req` is high. For the next ALE_CYC cycles (default 2), `ale` is high and the address low byte is driven on `ad_out` with `ad_oe` high. Neither strobe is low during that time.
- R3: The strobe selected by `we` falls exactly SETUP_CYC cycles (default 3) after `ale` falls: `we`=1 selects `wr_n` and `we`=0 selects `rd_n`. The other strobe stays high, and the two strobes are never low together.
- R4: The strobe stays low for exactly STB_CYC cycles (default 6).
- R5: In a read, `ad_oe` is low from the second cycle after `ale` falls until the access ends, including every cycle in which `rd_n` is low.
- R6: In a read, `rdata` takes the value that `ad_in` holds in the last cycle of `rd_n` low. The new value is visible in the first cycle after `rd_n` rises, and `rdata` does not change at any other time, including during writes.
- R7: In a write, the captured write data is on `ad_out` with `ad_oe` high from SETUP_CYC-1 cycles before `wr_n` falls until HOLD_CYC cycles (default 1) after `wr_n` rises.
- R8: After `rd_n` rises, the sequencer spends FLOAT_CYC cycles (default 2) with `ale` low and the bus released before the access completes.
- R9: `done` is high for exactly one cycle. It comes ALE_CYC+SETUP_CYC+STB_CYC+FLOAT_CYC cycles after the accepting edge for a read (13 by default) and ALE_CYC+SETUP_CYC+STB_CYC+HOLD_CYC cycles after it for a write (12 by default). A new request is accepted in the `done` cycle.
- R10: A request raised while an access is in progress is ignored. No further latch pulse or strobe follows it.
- R11: `addr_hi` carries the upper address byte captured at acceptance for the whole access, regardless of later changes on `addr`.
- R12: The address low byte stays driven on `ad_out` for one cycle after `ale` falls.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all timing counted in its periods |
| rst_n | input | 1 | Active-low synchronous reset |
| req | input | 1 | Start request, accepted only when idle |
| we | input | 1 | Direction: 1 write, 0 read |
| addr | input | 16 | Access address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Last captured read byte |
| done | output | 1 | One-cycle pulse at the end of an access |
| ale | output | 1 | Address latch enable, active high |
| rd_n | output | 1 | Read strobe, active low |
| wr_n | output | 1 | Write strobe, active low |
| addr_hi | output | 8 | Upper address byte |
| ad_out | output | 8 | Shared byte, outgoing value |
| ad_oe | output | 1 | Output enable for the shared byte |
| ad_in | input | 8 | Shared byte, incoming value |

## Verification
A phase counter that is off by one cycle moves a strobe edge or the `done` pulse. The bench compares every output in every cycle of an access against a timeline built from the parameters, so such a shift shows up in the first cycle where it happens. If the capture point is wrong, the bench sees a wrong byte in `rdata` one cycle after `rd_n` rises, because it drives `ad_in` with the correct byte only in the last strobe cycle. A wrong idle decision shows up within a cycle as an extra `ale` pulse, or as a back-to-back request that is never accepted.

// File: rtl/xmem_pkg.sv
package xmem_pkg;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_ADDR,
    PH_SETUP,
    PH_STROBE,
    PH_TAIL
  } phase_t;

  // cycles spent in one phase; the tail depends on the direction
  function automatic int unsigned phase_len(phase_t ph, logic wr,
                                            int unsigned a_cyc, int unsigned s_cyc,
                                            int unsigned w_cyc, int unsigned f_cyc,
                                            int unsigned h_cyc);
    case (ph)
      PH_ADDR:   return a_cyc;
      PH_SETUP:  return s_cyc;
      PH_STROBE: return w_cyc;
      PH_TAIL:   return wr ? h_cyc : f_cyc;
      default:   return 1;
    endcase
  endfunction

  function automatic phase_t next_phase(phase_t ph);
    case (ph)
      PH_ADDR:   return PH_SETUP;
      PH_SETUP:  return PH_STROBE;
      PH_STROBE: return PH_TAIL;
      default:   return PH_IDLE;
    endcase
  endfunction

  function automatic int unsigned max2(int unsigned x, int unsigned y);
    return (x > y) ? x : y;
  endfunction

endpackage

// File: rtl/xmem_phase_ctrl.sv
module xmem_phase_ctrl
  import xmem_pkg::*;
#(
  parameter int unsigned ALE_CYC   = 2,
  parameter int unsigned SETUP_CYC = 3,
  parameter int unsigned STB_CYC   = 6,
  parameter int unsigned FLOAT_CYC = 2,
  parameter int unsigned HOLD_CYC  = 1,
  parameter int unsigned CNT_W     = 3
) (
  input  logic   clk,
  input  logic   rst_n,
  input  logic   req,
  input  logic   we,
  output phase_t phase,
  output logic   is_wr,
  output logic   first,
  output logic   last,
  output logic   accept
);

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] len_m1;

  assign len_m1 = CNT_W'(phase_len(phase, is_wr, ALE_CYC, SETUP_CYC,
                                   STB_CYC, FLOAT_CYC, HOLD_CYC) - 1);
  assign first  = (cnt == '0);
  assign last   = (phase != PH_IDLE) && (cnt == len_m1);
  assign accept = (phase == PH_IDLE) && req;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase <= PH_IDLE;
      cnt   <= '0;
      is_wr <= 1'b0;
    end else if (accept) begin
      phase <= PH_ADDR;
      cnt   <= '0;
      is_wr <= we;
    end else if (last) begin
      phase <= next_phase(phase);
      cnt   <= '0;
    end else if (phase != PH_IDLE) begin
      cnt   <= cnt + 1'b1;
    end
  end

endmodule

// File: rtl/xmem_pin_decode.sv
module xmem_pin_decode
  import xmem_pkg::*;
(
  input  phase_t phase,
  input  logic   is_wr,
  input  logic   first,
  output logic   ale,
  output logic   rd_n,
  output logic   wr_n,
  output logic   ad_oe,
  output logic   sel_data
);

  logic addr_drv;
  logic data_drv;
  logic strobe;

  assign strobe   = (phase == PH_STROBE);
  assign ale      = (phase == PH_ADDR);
  assign rd_n     = !(strobe && !is_wr);
  assign wr_n     = !(strobe && is_wr);
  // address held one cycle past the latch edge
  assign addr_drv = ale || ((phase == PH_SETUP) && first);
  assign data_drv = is_wr && (((phase == PH_SETUP) && !first) || strobe ||
                              (phase == PH_TAIL));
  assign ad_oe    = addr_drv || data_drv;
  assign sel_data = data_drv;

endmodule

// File: rtl/xmem_datapath.sv
module xmem_datapath #(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept,
  input  logic              smp_evt,
  input  logic              fin_evt,
  input  logic              sel_data,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [DATA_W-1:0] ad_in,
  output logic [ADDR_W-DATA_W-1:0] addr_hi,
  output logic [DATA_W-1:0] ad_out,
  output logic [DATA_W-1:0] rdata,
  output logic              done
);

  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addr_q  <= '0;
      wdata_q <= '0;
      rdata   <= '0;
      done    <= 1'b0;
    end else begin
      if (accept) begin
        addr_q  <= addr;
        wdata_q <= wdata;
      end
      if (smp_evt) rdata <= ad_in;
      done <= fin_evt;
    end
  end

  assign addr_hi = addr_q[ADDR_W-1:DATA_W];
  assign ad_out  = sel_data ? wdata_q : addr_q[DATA_W-1:0];

endmodule

// File: rtl/xmem_seq.sv
module xmem_seq
  import xmem_pkg::*;
#(
  parameter int unsigned ADDR_W    = 16,
  parameter int unsigned DATA_W    = 8,
  parameter int unsigned ALE_CYC   = 2,
  parameter int unsigned SETUP_CYC = 3,
  parameter int unsigned STB_CYC   = 6,
  parameter int unsigned FLOAT_CYC = 2,
  parameter int unsigned HOLD_CYC  = 1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     req,
  input  logic                     we,
  input  logic [ADDR_W-1:0]        addr,
  input  logic [DATA_W-1:0]        wdata,
  output logic [DATA_W-1:0]        rdata,
  output logic                     done,
  output logic                     ale,
  output logic                     rd_n,
  output logic                     wr_n,
  output logic [ADDR_W-DATA_W-1:0] addr_hi,
  output logic [DATA_W-1:0]        ad_out,
  output logic                     ad_oe,
  input  logic [DATA_W-1:0]        ad_in
);

  localparam int unsigned MAX_CYC = max2(max2(max2(ALE_CYC, SETUP_CYC), STB_CYC),
                                         max2(FLOAT_CYC, HOLD_CYC));
  localparam int unsigned CNT_W   = $clog2(MAX_CYC + 1);

  phase_t phase;
  logic   is_wr;
  logic   first;
  logic   last;
  logic   accept;
  logic   sel_data;
  // named events for the checker
  logic   smp_evt;
  logic   fin_evt;

  assign smp_evt = (phase == PH_STROBE) && last && !is_wr;
  assign fin_evt = (phase == PH_TAIL) && last;

  xmem_phase_ctrl #(
    .ALE_CYC(ALE_CYC), .SETUP_CYC(SETUP_CYC), .STB_CYC(STB_CYC),
    .FLOAT_CYC(FLOAT_CYC), .HOLD_CYC(HOLD_CYC), .CNT_W(CNT_W)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n), .req(req), .we(we), .phase(phase),
    .is_wr(is_wr), .first(first), .last(last), .accept(accept)
  );

  xmem_pin_decode u_pins (
    .phase(phase), .is_wr(is_wr), .first(first), .ale(ale), .rd_n(rd_n),
    .wr_n(wr_n), .ad_oe(ad_oe), .sel_data(sel_data)
  );

  xmem_datapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dp (
    .clk(clk), .rst_n(rst_n), .accept(accept), .smp_evt(smp_evt),
    .fin_evt(fin_evt), .sel_data(sel_data), .addr(addr), .wdata(wdata),
    .ad_in(ad_in), .addr_hi(addr_hi), .ad_out(ad_out), .rdata(rdata),
    .done(done)
  );

endmodule

// File: rtl/xmem_seq_chk.sv
module xmem_seq_chk #(
  parameter int unsigned SETUP_CYC = 3,
  parameter int unsigned STB_CYC   = 6
) (
  input logic clk,
  input logic rst_n,
  input logic ale,
  input logic rd_n,
  input logic wr_n,
  input logic ad_oe,
  input logic done,
  input logic smp_evt
);

  logic [7:0] low_cnt;
  logic [7:0] gap_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      low_cnt <= '0;
      gap_cnt <= '0;
    end else begin
      low_cnt <= (!rd_n || !wr_n) ? low_cnt + 8'd1 : 8'd0;
      if (ale) gap_cnt <= '0;
      else if (gap_cnt != 8'hFF) gap_cnt <= gap_cnt + 8'd1;
    end
  end

  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(!rd_n && !wr_n)); // R3
  AST_ALE_NO_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    ale |-> (rd_n && wr_n)); // R2
  AST_STB_DELAY: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(rd_n) || $fell(wr_n)) |-> (gap_cnt == 8'(SETUP_CYC))); // R3
  AST_STB_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(rd_n) || $rose(wr_n)) |-> (low_cnt == 8'(STB_CYC))); // R4
  AST_RD_BUS_FREE: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_n |-> !ad_oe); // R5
  AST_SAMPLE_IN_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    smp_evt |-> !rd_n); // R6
  AST_WR_DATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_n || $rose(wr_n)) |-> ad_oe); // R7
  AST_RD_TURNAROUND: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rd_n) |-> (!ale && !ad_oe && !done)); // R8
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R9

endmodule

bind xmem_seq xmem_seq_chk #(.SETUP_CYC(SETUP_CYC), .STB_CYC(STB_CYC)) u_chk (
  .clk(clk), .rst_n(rst_n), .ale(ale), .rd_n(rd_n), .wr_n(wr_n),
  .ad_oe(ad_oe), .done(done), .smp_evt(smp_evt)
);

// File: tb/sim_xmem_seq.sv
module sim_xmem_seq;

  localparam int CLK_PERIOD = 10;
  localparam int TA = 2;  // latch enable cycles
  localparam int TS = 3;  // latch fall to strobe fall
  localparam int TW = 6;  // strobe width
  localparam int TF = 2;  // read turnaround
  localparam int TH = 1;  // write hold

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req = 1'b0;
  logic we = 1'b0;
  logic [15:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] ad_in = '0;
  logic [7:0] rdata, ad_out, addr_hi;
  logic done, ale, rd_n, wr_n, ad_oe;

  int n_run = 0;
  int n_fail = 0;
  logic [7:0] last_rd = 8'h00;

  always #(CLK_PERIOD/2) clk = ~clk;

  xmem_seq u0 (
    .clk(clk), .rst_n(rst_n), .req(req), .we(we), .addr(addr), .wdata(wdata),
    .rdata(rdata), .done(done), .ale(ale), .rd_n(rd_n), .wr_n(wr_n),
    .addr_hi(addr_hi), .ad_out(ad_out), .ad_oe(ad_oe), .ad_in(ad_in)
  );

  task automatic check(input bit ok, input string rq, input int k,
                       input logic [15:0] act, input logic [15:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s cycle %0d act=%h exp=%h", rq, k, act, exp);
    end
  endtask

  // one access; req raised at the current negedge, checks every cycle
  task automatic run_access(input bit wr, input logic [15:0] a, input logic [7:0] wd,
                            input logic [7:0] rv, input int intr_k);
    int t_sf, t_sl, t_done;
    t_sf   = TA + TS + 1;
    t_sl   = TA + TS + TW;
    t_done = t_sl + (wr ? TH : TF) + 1;
    req = 1'b1; we = wr; addr = a; wdata = wd; ad_in = rv ^ 8'h3C;
    @(negedge clk);
    addr = ~a; wdata = ~wd; req = 1'b0;
    for (int k = 1; k <= t_done; k++) begin
      bit e_ale, e_stb, e_oe;
      e_ale = (k <= TA);
      e_stb = (k >= t_sf) && (k <= t_sl);
      e_oe  = wr ? (k <= t_sl + TH) : (k <= TA + 1);
      check(ale == e_ale, "R2", k, 16'(ale), 16'(e_ale));
      check(rd_n == !(e_stb && !wr), "R4", k, 16'(rd_n), 16'(!(e_stb && !wr)));
      check(wr_n == !(e_stb && wr), "R4", k, 16'(wr_n), 16'(!(e_stb && wr)));
      if (k == t_sf - 1) check(rd_n && wr_n, "R3", k, {rd_n, wr_n}, 16'h3);
      if (k == t_sf) check((wr ? wr_n : rd_n) == 1'b0, "R3", k, {rd_n, wr_n}, wr ? 16'h2 : 16'h1);
      check(ad_oe == e_oe, wr ? "R7" : "R5", k, 16'(ad_oe), 16'(e_oe));
      if (e_oe && k <= TA + 1)
        check(ad_out == a[7:0], (k == TA + 1) ? "R12" : "R2", k, 16'(ad_out), 16'(a[7:0]));
      if (e_oe && k > TA + 1)
        check(ad_out == wd, "R7", k, 16'(ad_out), 16'(wd));
      check(addr_hi == a[15:8], "R11", k, 16'(addr_hi), 16'(a[15:8]));
      if (!wr && k > t_sl) check(!ale && !ad_oe, "R8", k, {ale, ad_oe}, 16'h0);
      check(done == (k == t_done), "R9", k, 16'(done), 16'(k == t_done));
      if (!wr && k == t_sl) check(rdata == last_rd, "R6", k, 16'(rdata), 16'(last_rd));
      if (!wr && k == t_sl + 1) check(rdata == rv, "R6", k, 16'(rdata), 16'(rv));
      if (wr) check(rdata == last_rd, "R6", k, 16'(rdata), 16'(last_rd));
      // stimulus for the rest of cycle k
      req = (k == intr_k);
      if (k == intr_k) we = 1'b1;
      ad_in = (!wr && k == t_sl) ? rv : (rv ^ 8'hC3);
      if (k < t_done) @(negedge clk);
    end
    req = 1'b0;
    if (!wr) last_rd = rv;
  endtask

  task automatic t_reset();
    req = 1'b1; we = 1'b1;
    repeat (3) @(negedge clk);
    check(rd_n && wr_n && !ale && !ad_oe && !done, "R1", 0,
          {rd_n, wr_n, ale, ad_oe, done}, 16'h18);
    req = 1'b0;
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check(rd_n && wr_n && !ale && !ad_oe && !done, "R1", 0,
          {rd_n, wr_n, ale, ad_oe, done}, 16'h18);
    check(rdata == 8'h00, "R1", 0, 16'(rdata), 16'h0);
  endtask

  task automatic t_read_basic();
    run_access(1'b0, 16'h12C4, 8'h00, 8'h3B, 0);
    @(negedge clk);
  endtask

  task automatic t_write_basic();
    run_access(1'b1, 16'hFE01, 8'h96, 8'h00, 0);
    @(negedge clk);
  endtask

  task automatic t_back_to_back();
    run_access(1'b0, 16'h0080, 8'h00, 8'hE7, 0);
    run_access(1'b1, 16'hA55A, 8'h01, 8'h00, 0);  // R9: accepted in done cycle
    run_access(1'b0, 16'h7F10, 8'h00, 8'h42, 0);
    @(negedge clk);
  endtask

  task automatic t_busy_ignore();
    run_access(1'b0, 16'h3344, 8'h00, 8'h9D, 5);
    for (int j = 0; j < 4; j++) begin
      @(negedge clk);
      check(!ale && rd_n && wr_n && !ad_oe, "R10", j, {ale, rd_n, wr_n, ad_oe}, 16'h6);
    end
    check(rdata == 8'h9D, "R10", 0, 16'(rdata), 16'h9D);
  endtask

  initial begin
    t_reset();
    t_read_basic();
    t_write_basic();
    t_back_to_back();
    t_busy_ignore();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    n_run++;
    n_fail++;
    $display("FAIL watchdog R9 act=hung exp=finished");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule